// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every cause that can restart the chip into a single active-low system reset. The causes are a power-on reset input, an active-low external reset pin, a precise low-voltage detector on the regulator outputs (a digital half plus an analog half), an ultra-low-power low-voltage detector, a software trigger bit and a watchdog request. Each cause produces exactly the same response as power-on: the system reset is driven low and held for a fixed stretch after the last active cause goes away.

Each cause is gated by the current power mode. The precise detector counts while running and during buzz windows in sleep, and is ignored in hibernate. The ultra-low-power detector is always watched but counts only in sleep or hibernate. The external pin and the watchdog count in every mode. The analog half of the precise detector counts only while the analog regulator is enabled. The software trigger can be blocked by a disable bit in the control register. A cause register records which sources started and fed the most recent reset; only power-on clears it.

The external pin pulls the reset low asynchronously, and its release passes through a synchronizer before the stretch counter starts. A small register port gives software the control register (select 0) and the cause register (select 1).

Top module: `rst_hub`

## Requirements
- R1: Any gated source that is active at a rising clock edge drives `sys_rst_n` low from that edge on, with the same response as power-on (control register cleared, stretch restarted).
- R2: `ext_rst_n` low forces `sys_rst_n` low at once, in every power mode, for as long as the pin is low; its release passes a 2-stage synchronizer, so a pin held low for N sampled clock periods keeps `sys_rst_n` low for N+19 samples with HOLD=16.
- R3: `sys_rst_n` returns high on the (HOLD+1)th rising edge after the last edge at which a gated source was sampled active, so a level source held active for N edges gives N+HOLD low cycles (HOLD=16 by default).
- R4: The precise detector input is `prec_dig_trip | (ana_reg_en & prec_ana_trip)`; it counts when `pwr_mode`=0 (run), or `pwr_mode`=1 (sleep) with `buzz`=1, and is ignored in `pwr_mode`=2 or 3 (hibernate).
- R5: `ulp_trip` is ignored in run mode (`pwr_mode`=0) and counts in sleep and hibernate (`pwr_mode`=1, 2, 3).
- R6: `wdog_req` causes a reset in every power mode.
- R7: A write to select 0 with data bit 0 set and data bit 1 clear starts a software reset one cycle later; data bit 1 is stored as the software-disable bit (read back at bit 1 of select 0) and blocks the trigger in the same write; the control register clears on any system reset and writes are ignored while `sys_rst_n` is low.
- R8: The cause register (select 1) uses bit 0 power-on, bit 1 external pin, bit 2 precise detector, bit 3 ultra-low-power detector, bit 4 software, bit 5 watchdog; a source active while `sys_rst_n` is high replaces the register with the active set, and sources active later in the same reset are OR-ed in.
- R9: `por_n` low asserts `sys_rst_n` asynchronously and sets the cause register to 0x01; after release `sys_rst_n` stays low for HOLD+1 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| prec_dig_trip | input | 1 | Precise detector, digital regulator half tripped |
| prec_ana_trip | input | 1 | Precise detector, analog regulator half tripped |
| ana_reg_en | input | 1 | Analog regulator enabled |
| ulp_trip | input | 1 | Ultra-low-power low-voltage detector tripped |
| wdog_req | input | 1 | Watchdog reset request |
| pwr_mode | input | 2 | 0 run, 1 sleep, 2 or 3 hibernate |
| buzz | input | 1 | Sleep buzz window active |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 control register, 1 cause register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
On every cycle the assertions check that a gated source is followed by reset, that the external pin keeps the output low, that no release comes before the stretch has run out, that the mode gates of both detectors and the software-disable bit hold, and that a fresh reset loads the cause register with exactly the sources seen. Only the bench scenarios show the exact stretch lengths for each source, the two extra cycles the pin synchronizer adds, the cause value after a whole sequence of resets with OR-ing inside one reset, and that control writes during reset are lost.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;

  localparam int NSRC = 6;

  // cause register bit positions (software decodes these)
  localparam int C_POR  = 0;
  localparam int C_EXT  = 1;
  localparam int C_PREC = 2;
  localparam int C_ULP  = 3;
  localparam int C_SW   = 4;
  localparam int C_WDOG = 5;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_HIB   = 2'd2,
    PM_HIB2  = 2'd3
  } pmode_e;

  // precise detector counts when running, or in sleep during a buzz window
  function automatic logic prec_window(input logic [1:0] mode, input logic bz);
    return (mode == PM_RUN) || ((mode == PM_SLEEP) && bz);
  endfunction

  // ultra-low-power detector counts in any low-power mode
  function automatic logic low_power(input logic [1:0] mode);
    return mode != PM_RUN;
  endfunction

  // precise detector: analog half only while the analog regulator runs
  function automatic logic prec_level(input logic dig, input logic ana,
                                      input logic ana_en);
    return dig | (ana & ana_en);
  endfunction

  // fresh reset replaces the cause set, later sources in one reset OR in
  function automatic logic [NSRC-1:0] cause_next(input logic [NSRC-1:0] cur,
                                                 input logic [NSRC-1:0] act,
                                                 input logic merge);
    return merge ? (cur | act) : act;
  endfunction

endpackage

// File: rtl/rst_hub_sync.sv
module rst_hub_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= RST_VAL;
        else         chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= {STAGES{RST_VAL}};
        else         chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rst_hub_gate.sv
module rst_hub_gate
  import rst_hub_pkg::*;
(
  input  logic            ext_sync_n,
  input  logic            prec_dig,
  input  logic            prec_ana,
  input  logic            ana_en,
  input  logic            ulp,
  input  logic            sw_pulse,
  input  logic            wdog,
  input  logic [1:0]      mode,
  input  logic            bz,
  output logic [NSRC-1:0] active
);

  logic prec_open;
  logic ulp_open;

  assign prec_open = prec_window(mode, bz);
  assign ulp_open  = low_power(mode);

  always_comb begin
    active         = '0;
    active[C_EXT]  = ~ext_sync_n;
    active[C_PREC] = prec_open & prec_level(prec_dig, prec_ana, ana_en);
    active[C_ULP]  = ulp_open & ulp;
    active[C_SW]   = sw_pulse;
    active[C_WDOG] = wdog;
  end

endmodule

// File: rtl/rst_hub_stretch.sv
module rst_hub_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic any_active,
  output logic rst_n_q
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt     <= HOLD_V;
      rst_n_q <= 1'b0;
    end else if (any_active) begin
      cnt     <= HOLD_V;
      rst_n_q <= 1'b0;
    end else if (cnt != '0) begin
      cnt     <= cnt - 1'b1;
      rst_n_q <= 1'b0;
    end else begin
      rst_n_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rst_hub_regs.sv
module rst_hub_regs
  import rst_hub_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            sys_rst_n,
  input  logic [NSRC-1:0] active,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            sw_pulse,
  output logic            sw_dis,
  output logic [NSRC-1:0] cause
);

  localparam logic [NSRC-1:0] POR_CAUSE = NSRC'(1) << C_POR;

  logic ctl_wen;
  logic in_rst_seen;
  logic merge;

  assign ctl_wen = reg_wr & sys_rst_n & ~reg_sel;
  assign merge   = in_rst_seen & ~sys_rst_n;

  // control: software-disable bit and trigger pulse
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sw_dis   <= 1'b0;
      sw_pulse <= 1'b0;
    end else if (!sys_rst_n) begin
      sw_dis   <= 1'b0;
      sw_pulse <= 1'b0;
    end else begin
      sw_pulse <= ctl_wen & reg_wdata[0] & ~reg_wdata[1];
      if (ctl_wen) sw_dis <= reg_wdata[1];
    end
  end

  // cause capture, cleared only by power-on
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause       <= POR_CAUSE;
      in_rst_seen <= 1'b1;
    end else if (|active) begin
      cause       <= cause_next(cause, active, merge);
      in_rst_seen <= 1'b1;
    end else if (sys_rst_n) begin
      in_rst_seen <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) reg_rdata[NSRC-1:0] = cause;
    else         reg_rdata[1]        = sw_dis;
  end

endmodule

// File: rtl/rst_hub.sv
module rst_hub
  import rst_hub_pkg::*;
#(
  parameter int HOLD      = 16,
  parameter int SYNC_STG  = 2,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ext_rst_n,
  input  logic          prec_dig_trip,
  input  logic          prec_ana_trip,
  input  logic          ana_reg_en,
  input  logic          ulp_trip,
  input  logic          wdog_req,
  input  logic [1:0]    pwr_mode,
  input  logic          buzz,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sys_rst_n
);

  logic            hard_arst_n;
  logic            ext_sync_n;
  logic            sw_pulse;
  logic            sw_dis;
  logic            any_active;
  logic [NSRC-1:0] src_active;
  logic [NSRC-1:0] cause_q;

  // power-on or the pin pull the output low with no clock
  assign hard_arst_n = por_n & ext_rst_n;

  rst_hub_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      (ext_rst_n),
    .q      (ext_sync_n)
  );

  rst_hub_gate u_gate (
    .ext_sync_n (ext_sync_n),
    .prec_dig   (prec_dig_trip),
    .prec_ana   (prec_ana_trip),
    .ana_en     (ana_reg_en),
    .ulp        (ulp_trip),
    .sw_pulse   (sw_pulse),
    .wdog       (wdog_req),
    .mode       (pwr_mode),
    .bz         (buzz),
    .active     (src_active)
  );

  assign any_active = |src_active;

  rst_hub_stretch #(.HOLD(HOLD)) u_stretch (
    .clk        (clk),
    .arst_n     (hard_arst_n),
    .any_active (any_active),
    .rst_n_q    (sys_rst_n)
  );

  rst_hub_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .active    (src_active),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sw_pulse  (sw_pulse),
    .sw_dis    (sw_dis),
    .cause     (cause_q)
  );

endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk
  import rst_hub_pkg::*;
#(
  parameter int HOLD = 16
) (
  input logic            clk,
  input logic            por_n,
  input logic            ext_rst_n,
  input logic            sys_rst_n,
  input logic [1:0]      pwr_mode,
  input logic            buzz,
  input logic [NSRC-1:0] active,
  input logic            sw_dis,
  input logic [NSRC-1:0] cause
);

  localparam int QW = $clog2(HOLD + 2) + 1;
  localparam logic [QW-1:0] QMAX = '1;

  // cycles since a gated source was last sampled active
  logic [QW-1:0] quiet;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              quiet <= '0;
    else if (|active)        quiet <= '0;
    else if (quiet != QMAX)  quiet <= quiet + 1'b1;
  end

  AST_SRC_RESETS: assert property (@(posedge clk) disable iff (!por_n)
    (|active) |=> !sys_rst_n);  // R1

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |-> !sys_rst_n);  // R2

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> (quiet >= QW'(HOLD)));  // R3

  AST_PREC_GATED: assert property (@(posedge clk) disable iff (!por_n)
    ((pwr_mode[1]) || (pwr_mode == 2'd1 && !buzz)) |-> !active[C_PREC]);  // R4

  AST_ULP_RUN_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_mode == 2'd0) |-> !active[C_ULP]);  // R5

  AST_SW_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
    active[C_SW] |-> !sw_dis);  // R7

  AST_FRESH_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    ((|active) && sys_rst_n) |=> (cause == $past(active)));  // R8

  AST_POR_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_n) |-> (cause == NSRC'(1)));  // R9

endmodule

bind rst_hub rst_hub_chk #(.HOLD(HOLD)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .ext_rst_n (ext_rst_n),
  .sys_rst_n (sys_rst_n),
  .pwr_mode  (pwr_mode),
  .buzz      (buzz),
  .active    (src_active),
  .sw_dis    (sw_dis),
  .cause     (cause_q)
);

// File: tb/rst_hub_bench.sv
`timescale 1ns/1ps
module rst_hub_bench;

  localparam int HOLD = 16;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       prec_dig_trip = 1'b0;
  logic       prec_ana_trip = 1'b0;
  logic       ana_reg_en = 1'b1;
  logic       ulp_trip = 1'b0;
  logic       wdog_req = 1'b0;
  logic [1:0] pwr_mode = 2'd0;
  logic       buzz = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_rst_n;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  rst_hub u_rst_hub (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .prec_dig_trip(prec_dig_trip), .prec_ana_trip(prec_ana_trip),
    .ana_reg_en(ana_reg_en), .ulp_trip(ulp_trip), .wdog_req(wdog_req),
    .pwr_mode(pwr_mode), .buzz(buzz), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n)
  );

  // stimulus layout: {wdog, ulp, prec_ana, prec_dig, ext}
  typedef struct packed {
    logic [1:0] mode;
    logic       bz;
    logic       ana_en;
    logic [4:0] stim;
    logic [3:0] n;
    logic       exp_rst;
    logic [5:0] exp_cause;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b1, 5'b00010, 4'd3, 1'b1, 6'h04},  // R4 run digital
    '{2'd0, 1'b0, 1'b1, 5'b01000, 4'd3, 1'b0, 6'h04},  // R5 run ignored
    '{2'd1, 1'b0, 1'b1, 5'b01000, 4'd3, 1'b1, 6'h08},  // R5 sleep
    '{2'd2, 1'b0, 1'b1, 5'b01000, 4'd3, 1'b1, 6'h08},  // R5 hibernate
    '{2'd1, 1'b0, 1'b1, 5'b00010, 4'd3, 1'b0, 6'h08},  // R4 sleep no buzz
    '{2'd1, 1'b1, 1'b1, 5'b00010, 4'd3, 1'b1, 6'h04},  // R4 sleep buzz
    '{2'd2, 1'b1, 1'b1, 5'b00010, 4'd3, 1'b0, 6'h04},  // R4 hibernate buzz
    '{2'd0, 1'b0, 1'b0, 5'b00100, 4'd3, 1'b0, 6'h04},  // R4 analog off
    '{2'd1, 1'b0, 1'b1, 5'b10000, 4'd2, 1'b1, 6'h20},  // R6 sleep
    '{2'd0, 1'b0, 1'b1, 5'b00100, 4'd4, 1'b1, 6'h04},  // R4 analog on
    '{2'd0, 1'b0, 1'b1, 5'b10010, 4'd5, 1'b1, 6'h24},  // R8 two at once
    '{2'd2, 1'b0, 1'b1, 5'b10000, 4'd2, 1'b1, 6'h20},  // R6 hibernate
    '{2'd3, 1'b0, 1'b1, 5'b01000, 4'd2, 1'b1, 6'h08},  // R5 mode 3
    '{2'd3, 1'b1, 1'b1, 5'b00010, 4'd2, 1'b0, 6'h08}   // R4 mode 3 buzz
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] s);
    ext_rst_n     = ~s[0];
    prec_dig_trip = s[1];
    prec_ana_trip = s[2];
    ulp_trip      = s[3];
    wdog_req      = s[4];
  endtask

  task automatic sample(inout int low);
    #1;
    if (!sys_rst_n) low++;
  endtask

  // drive a stimulus for n periods, then count all low samples
  task automatic stim_count(input logic [4:0] s, input int n, output int low);
    low = 0;
    @(negedge clk); apply(s); sample(low);
    for (int k = 1; k < n; k++) begin @(negedge clk); sample(low); end
    @(negedge clk); apply(5'b0); sample(low);
    for (int k = 0; k < 60; k++) begin @(negedge clk); sample(low); end
  endtask

  task automatic ctl_write(input logic [7:0] d, output int low);
    low = 0;
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = d; sample(low);
    @(negedge clk); reg_wr = 1'b0; sample(low);
    for (int k = 0; k < 60; k++) begin @(negedge clk); sample(low); end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk); reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic por_cycle(output int low);
    low = 0;
    @(negedge clk); por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; sample(low);
    for (int k = 0; k < 60; k++) begin @(negedge clk); sample(low); end
  endtask

  initial begin
    #2ms;
    n_chk++; n_err++;
    $display("FAIL watchdog expired before the bench completed");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int low;
    logic [7:0] v;

    // power-on
    repeat (3) @(negedge clk);
    #1 chk("R9 output low while por_n low", 32'(sys_rst_n), 0);
    @(negedge clk); por_n = 1'b1; low = 0; sample(low);
    for (int k = 0; k < 40; k++) begin @(negedge clk); sample(low); end
    chk("R9 low samples after power-on release", 32'(low), HOLD + 1);
    rd(1'b1, v); chk("R9 cause after power-on", 32'(v), 32'h01);
    rd(1'b0, v); chk("R7 control after power-on", 32'(v), 32'h00);

    // table of level-source vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pwr_mode = VEC[i].mode; buzz = VEC[i].bz; ana_reg_en = VEC[i].ana_en;
      repeat (2) @(negedge clk);
      stim_count(VEC[i].stim, int'(VEC[i].n), low);
      chk($sformatf("R1 R3 vector %0d low samples", i), 32'(low),
          VEC[i].exp_rst ? 32'(int'(VEC[i].n) + HOLD) : 32'd0);
      rd(1'b1, v);
      chk($sformatf("R8 vector %0d cause", i), 32'(v), 32'(VEC[i].exp_cause));
    end
    @(negedge clk); pwr_mode = 2'd0; buzz = 1'b0; ana_reg_en = 1'b1;

    // OR-ing within one reset: watchdog, then precise during the stretch
    low = 0;
    @(negedge clk); apply(5'b10000); sample(low);
    @(negedge clk); sample(low);
    @(negedge clk); apply(5'b0); sample(low);
    repeat (4) begin @(negedge clk); sample(low); end
    @(negedge clk); apply(5'b00010); sample(low);
    @(negedge clk); apply(5'b0); sample(low);
    for (int k = 0; k < 60; k++) begin @(negedge clk); sample(low); end
    chk("R3 low samples, stretch restarted by second source", 32'(low), 2 + 5 + 1 + HOLD);
    rd(1'b1, v); chk("R8 cause merged in one reset", 32'(v), 32'h24);

    // software trigger
    ctl_write(8'h01, low);
    chk("R7 software trigger low samples", 32'(low), HOLD + 1);
    rd(1'b1, v); chk("R7 software cause", 32'(v), 32'h10);

    ctl_write(8'h02, low);
    chk("R7 disable write no reset", 32'(low), 0);
    rd(1'b0, v); chk("R7 disable bit readback", 32'(v), 32'h02);
    ctl_write(8'h03, low);
    chk("R7 trigger with disable no reset", 32'(low), 0);
    rd(1'b0, v); chk("R7 disable bit kept", 32'(v), 32'h02);
    rd(1'b1, v); chk("R7 cause untouched by blocked trigger", 32'(v), 32'h10);
    ctl_write(8'h02, low);
    stim_count(5'b10000, 1, low);
    chk("R1 watchdog low samples", 32'(low), 1 + HOLD);
    rd(1'b0, v); chk("R1 control cleared by reset", 32'(v), 32'h00);
    ctl_write(8'h01, low);
    chk("R7 trigger after enable", 32'(low), HOLD + 1);

    // external pin
    @(negedge clk); apply(5'b00001); #1;
    chk("R2 pin asserts output without a clock edge", 32'(sys_rst_n), 0);
    low = 1;
    for (int k = 1; k < 4; k++) begin @(negedge clk); sample(low); end
    @(negedge clk); apply(5'b0); sample(low);
    for (int k = 0; k < 60; k++) begin @(negedge clk); sample(low); end
    chk("R2 pin low samples", 32'(low), 4 + HOLD + SYNC + 1);
    rd(1'b1, v); chk("R2 pin cause", 32'(v), 32'h02);

    @(negedge clk); pwr_mode = 2'd2;
    stim_count(5'b00001, 1, low);
    chk("R2 pin in hibernate", 32'(low), 1 + HOLD + SYNC + 1);
    @(negedge clk); pwr_mode = 2'd0;

    // writes during reset are lost, power-on clears cause
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h02;
    @(negedge clk); reg_wr = 1'b0;
    repeat (30) @(negedge clk);
    rd(1'b0, v); chk("R7 write during reset ignored", 32'(v), 32'h00);
    rd(1'b1, v); chk("R9 power-on clears cause", 32'(v), 32'h01);

    stim_count(5'b10000, 2, low);
    por_cycle(low);
    chk("R9 power-on stretch after prior reset", 32'(low), HOLD + 1);
    rd(1'b1, v); chk("R9 cause back to power-on", 32'(v), 32'h01);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule